// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test port for board interconnect checks and production test. It runs on its own test clock. A mode-select line drives the sixteen-state controller, and a serial input and a serial output carry the data. A 3-bit instruction picks one of three data paths between the serial input and output. The paths are a single bypass flop, a 32-bit identification word, and a boundary register of three cells per pin: one for the observed input, one for the output value and one for the output enable.

In the test instructions the block takes each pin's output value and output enable away from the core and drives them from the held stage of the boundary register. One instruction floats every pin. Any other instruction leaves the pins under core control. The serial output has its own enable and is active only while a register is shifting.

Controller states, with the transition taken for mode-select 0 / 1. Reset: Idle / Reset. Idle: Idle / DR-Select. DR-Select: DR-Capture / IR-Select. DR-Capture: DR-Shift / DR-Exit1. DR-Shift: DR-Shift / DR-Exit1. DR-Exit1: DR-Pause / DR-Update. DR-Pause: DR-Pause / DR-Exit2. DR-Exit2: DR-Shift / DR-Update. DR-Update: Idle / DR-Select. IR-Select: IR-Capture / Reset. The IR-Capture through IR-Update states mirror the DR states, and IR-Update goes to Idle / DR-Select.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller moves between the sixteen states listed above on each rising test-clock edge, according to the mode-select line. Five consecutive edges with mode-select high reach Reset from any state.
- R2: A low `trst_n` forces Reset asynchronously. One rising edge spent in Reset loads the instruction 3'b010 (identify) and returns every pin to core control (`test_sel`=0, `pad_out`=`core_out`, `pad_oe`=`core_oe`).
- R3: IR-Capture loads the instruction shifter with 3'b001, and the shifter sends its bit 0 out first. A new instruction takes effect only in IR-Update, so the pins keep their old control during shifting and exit.
- R4: With instruction 3'b010 a data scan shifts out the 32-bit identification word, least significant bit first, and bit 0 always reads 1.
- R5: With instruction 3'b111 the data path is one flop that captures 0. The scan output therefore reads 0 first and then the serial input delayed by one bit.
- R6: The unassigned codes 3'b101 and 3'b110 act exactly like 3'b111: one-bit path, pins under core control.
- R7: Instruction 3'b001 (sample/preload) selects the boundary register. Its capture loads bits [N-1:0] with `pin_in`, bits [2N-1:N] with `core_out` and bits [3N-1:2N] with `core_oe`, and bit 0 is shifted out first. The pins stay under core control.
- R8: Instruction 3'b000 (external test) sets `test_sel` and drives `pad_out` from held bits [2N-1:N] and `pad_oe` from held bits [3N-1:2N].
- R9: Instruction 3'b100 (clamp) uses the one-bit path and drives the pins from the held boundary stage. The pins do not change while it is active, whatever the scans or the core do.
- R10: Instruction 3'b011 (float) sets `test_sel`, forces every `pad_oe` bit to 0 and uses the one-bit path.
- R11: The serial output changes only on falling test-clock edges. `tdo_oe` is high only while the controller is in DR-Shift or IR-Shift.
- R12: The held boundary stage changes only in DR-Update while instruction 3'b000 or 3'b001 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Serial output enable |
| pin_in | input | NPINS | Values observed at the pins |
| core_out | input | NPINS | Core output values |
| core_oe | input | NPINS | Core output enables |
| test_sel | output | 1 | High when the pins are under test control |
| pad_out | output | NPINS | Output value to the pins |
| pad_oe | output | NPINS | Output enable to the pins |

## Verification
A wrong controller state shows at the ports within one falling edge as a wrong `tdo_oe`. It shows within one scan as a shifted or missing bit on `tdo`, because each capture value is known (001, the identification word, 0, or the sampled pins). A wrong instruction or a wrong held stage shows at `test_sel`, `pad_out` and `pad_oe` one edge after Update or after one edge in Reset. The clamp hold is checked by scanning and by moving the core values while watching the pins.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 3'b000,
        OP_SAMPLE = 3'b001,
        OP_IDCODE = 3'b010,
        OP_HIGHZ  = 3'b011,
        OP_CLAMP  = 3'b100,
        OP_RSV5   = 3'b101,
        OP_RSV6   = 3'b110,
        OP_BYPASS = 3'b111
    } tap_op_e;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

    typedef struct packed {
        logic sel_bsr;     // boundary register on the serial path
        logic sel_id;      // identification register on the serial path
        logic pins_test;   // pins driven from the held boundary stage
        logic pins_float;  // all output enables forced off
    } tap_dec_t;

    function automatic tap_dec_t decode_op(input logic [IR_W-1:0] op);
        tap_dec_t d;
        d = '0;
        unique case (op)
            OP_EXTEST: begin d.sel_bsr = 1'b1; d.pins_test = 1'b1; end
            OP_SAMPLE: d.sel_bsr = 1'b1;
            OP_IDCODE: d.sel_id = 1'b1;
            OP_HIGHZ:  begin d.pins_test = 1'b1; d.pins_float = 1'b1; end
            OP_CLAMP:  d.pins_test = 1'b1;
            default:   d = '0;   // bypass and the two unassigned codes
        endcase
        return d;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o,
    output logic       in_tlr_o,
    output logic       cap_dr_o,
    output logic       sh_dr_o,
    output logic       upd_dr_o,
    output logic       cap_ir_o,
    output logic       sh_ir_o,
    output logic       upd_ir_o
);

    tap_state_e state_q, state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_TLR;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
            default:   state_d = ST_TLR;
        endcase
    end

    always_comb begin
        in_tlr_o = 1'b0;
        cap_dr_o = 1'b0;
        sh_dr_o  = 1'b0;
        upd_dr_o = 1'b0;
        cap_ir_o = 1'b0;
        sh_ir_o  = 1'b0;
        upd_ir_o = 1'b0;
        unique case (state_q)
            ST_TLR:    in_tlr_o = 1'b1;
            ST_CAP_DR: cap_dr_o = 1'b1;
            ST_SH_DR:  sh_dr_o  = 1'b1;
            ST_UPD_DR: upd_dr_o = 1'b1;
            ST_CAP_IR: cap_ir_o = 1'b1;
            ST_SH_IR:  sh_ir_o  = 1'b1;
            ST_UPD_IR: upd_ir_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            in_tlr,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    input  logic            tdi,
    output logic            so,
    output logic [IR_W-1:0] op_o,
    output tap_dec_t        dec_o
);

    logic [IR_W-1:0] shf_q;
    logic [IR_W-1:0] op_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  shf_q <= '0;
        else if (cap) shf_q <= IR_CAPTURE_PAT;
        else if (sh)  shf_q <= {tdi, shf_q[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     op_q <= OP_IDCODE;
        else if (in_tlr) op_q <= OP_IDCODE;
        else if (upd)    op_q <= shf_q;
    end

    assign so    = shf_q[0];
    assign op_o  = op_q;
    assign dec_o = decode_op(op_q);

endmodule

// File: rtl/jtag_tap_bsr.sv
module jtag_tap_bsr #(
    parameter int CELLS = 12
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sel,
    input  logic             cap,
    input  logic             sh,
    input  logic             upd,
    input  logic             tdi,
    input  logic [CELLS-1:0] cap_val,
    output logic             so,
    output logic [CELLS-1:0] hold_o
);

    logic [CELLS-1:0] sr_q;
    logic [CELLS-1:0] hold_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)         sr_q <= '0;
        else if (sel && cap) sr_q <= cap_val;
        else if (sel && sh)  sr_q <= {tdi, sr_q[CELLS-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)         hold_q <= '0;
        else if (sel && upd) hold_q <= sr_q;
    end

    assign so     = sr_q[0];
    assign hold_o = hold_q;

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int          NPINS   = 4,
    parameter logic [31:0] ID_WORD = 32'h0B57_A0C2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    output logic             test_sel,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    localparam int          CELLS   = 3 * NPINS;
    localparam int          ID_W    = 32;
    localparam logic [ID_W-1:0] ID_CAP = {ID_WORD[ID_W-1:1], 1'b1};

    tap_state_e      state;
    logic            in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic            ir_so, bsr_so;
    logic [IR_W-1:0] ir_op;
    tap_dec_t        dec;
    logic            sel_bsr, sel_id, sel_byp;
    logic [CELLS-1:0] bsr_hold;
    logic [ID_W-1:0]  id_q;
    logic             byp_q;
    logic             tdo_q, tdo_oe_q, tdo_d;

    jtag_tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state_o  (state),
        .in_tlr_o (in_tlr),
        .cap_dr_o (cap_dr),
        .sh_dr_o  (sh_dr),
        .upd_dr_o (upd_dr),
        .cap_ir_o (cap_ir),
        .sh_ir_o  (sh_ir),
        .upd_ir_o (upd_ir)
    );

    jtag_tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .in_tlr (in_tlr),
        .cap    (cap_ir),
        .sh     (sh_ir),
        .upd    (upd_ir),
        .tdi    (tdi),
        .so     (ir_so),
        .op_o   (ir_op),
        .dec_o  (dec)
    );

    assign sel_bsr = dec.sel_bsr;
    assign sel_id  = dec.sel_id;
    assign sel_byp = !(dec.sel_bsr || dec.sel_id);

    jtag_tap_bsr #(.CELLS(CELLS)) u_bsr (
        .tck     (tck),
        .trst_n  (trst_n),
        .sel     (sel_bsr),
        .cap     (cap_dr),
        .sh      (sh_dr),
        .upd     (upd_dr),
        .tdi     (tdi),
        .cap_val ({core_oe, core_out, pin_in}),
        .so      (bsr_so),
        .hold_o  (bsr_hold)
    );

    // identification word
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 id_q <= '0;
        else if (sel_id && cap_dr)   id_q <= ID_CAP;
        else if (sel_id && sh_dr)    id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // single-bit path
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (sel_byp && cap_dr)  byp_q <= 1'b0;
        else if (sel_byp && sh_dr)   byp_q <= tdi;
    end

    always_comb begin
        tdo_d = 1'b0;
        unique case (state)
            ST_SH_IR: tdo_d = ir_so;
            ST_SH_DR: tdo_d = sel_bsr ? bsr_so : (sel_id ? id_q[0] : byp_q);
            default:  tdo_d = 1'b0;
        endcase
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_oe_q <= 1'b0;
        end else begin
            tdo_q    <= tdo_d;
            tdo_oe_q <= (state == ST_SH_DR) || (state == ST_SH_IR);
        end
    end

    assign tdo      = tdo_oe_q ? tdo_q : 1'b0;
    assign tdo_oe   = tdo_oe_q;
    assign test_sel = dec.pins_test;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign pad_out[p] = dec.pins_test ? bsr_hold[NPINS + p] : core_out[p];
        assign pad_oe[p]  = dec.pins_float ? 1'b0 :
                            (dec.pins_test ? bsr_hold[2*NPINS + p] : core_oe[p]);
    end

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
    import jtag_tap_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int CELLS = 12
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input tap_state_e       state,
    input logic [IR_W-1:0]  op,
    input logic             tdo_oe,
    input logic             test_sel,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [CELLS-1:0] hold,
    input logic             upd_dr,
    input logic             sel_bsr
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ones_q <= '0;
        else if (!tms)   ones_q <= '0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    p_five_ones_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state == ST_TLR));

    p_reset_core_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> !test_sel);

    p_ir_only_update_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(op));

    p_clamp_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_CLAMP) |=> (op != OP_CLAMP) || ($stable(pad_out) && $stable(pad_oe)));

    p_float_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_HIGHZ) |-> (pad_oe == '0));

    p_tdo_window_r11: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

    p_hold_gate_r12: assert property (@(posedge tck) disable iff (!trst_n)
        !(upd_dr && sel_bsr) |=> $stable(hold));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk #(.NPINS(NPINS), .CELLS(CELLS)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .state    (state),
    .op       (ir_op),
    .tdo_oe   (tdo_oe),
    .test_sel (test_sel),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .hold     (bsr_hold),
    .upd_dr   (upd_dr),
    .sel_bsr  (sel_bsr)
);

// File: tb/jtag_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_tb_top;

    localparam int          NPINS = 4;
    localparam logic [31:0] IDW   = 32'h0B57_A0C2;
    localparam logic [31:0] IDEXP = 32'h0B57_A0C3;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_oe, test_sel;
    logic [NPINS-1:0] pin_in = '0, core_out = '0, core_oe = '0;
    logic [NPINS-1:0] pad_out, pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 tck = ~tck;   // 250 MHz

    jtag_tap_ctrl #(.NPINS(NPINS), .ID_WORD(IDW)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .test_sel(test_sel), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drives one rising edge; returns tdo and tdo_oe seen in the low phase
    task automatic tick(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck);
        #0.5;
        tms = m;
        tdi = d;
        #1;
        o  = tdo;
        oe = tdo_oe;
        @(posedge tck);
    endtask

    task automatic step(input logic m);
        logic o, oe;
        tick(m, 1'b0, o, oe);
    endtask

    task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap, output logic mid_sel);
        logic o, oe;
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, op[i], o, oe);
            cap[i] = o;
        end
        #1;
        mid_sel = test_sel;
        step(1); step(0);
        #1;
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout, output bit oe_ok);
        logic o, oe;
        dout  = '0;
        oe_ok = 1'b1;
        step(1); step(0); step(0);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o, oe);
            dout[i] = o;
            if (!oe) oe_ok = 1'b0;
        end
        step(1); step(0);
        #1;
    endtask

    task automatic load_ir(input logic [2:0] op);
        logic [2:0] c;
        logic m;
        scan_ir(op, c, m);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        bit ok;
        core_out = 4'h6; core_oe = 4'h9;
        trst_n = 1'b0;
        #7;
        check(tdo_oe == 1'b0, "R11 tdo_oe in reset", tdo_oe, 0);
        check(test_sel == 1'b0, "R2 test_sel in reset", test_sel, 0);
        check(pad_out == core_out && pad_oe == core_oe, "R2 pins to core",
              {pad_oe, pad_out}, {core_oe, core_out});
        trst_n = 1'b1;
        step(0);
        scan_dr(32, 64'h0, d, ok);
        check(d[31:0] == IDEXP, "R4 identification word", d[31:0], IDEXP);
        check(d[0] == 1'b1, "R4 bit0 is one", d[0], 1);
        check(ok, "R11 tdo_oe during shift", ok, 1);
        check(tdo_oe == 1'b0, "R11 tdo_oe idle", tdo_oe, 0);
    endtask

    task automatic t_bypass(input logic [2:0] op, input string req);
        logic [63:0] d;
        bit ok;
        load_ir(op);
        scan_dr(8, 64'hB5, d, ok);
        check(d[7:0] == 8'h6A, req, d[7:0], 8'h6A);   // {B5[6:0],0}
        check(test_sel == 1'b0, req, test_sel, 0);
    endtask

    task automatic t_sample_extest;
        logic [63:0] d;
        logic [2:0] c;
        logic m;
        bit ok;
        pin_in = 4'h3; core_out = 4'hA; core_oe = 4'h5;
        scan_ir(3'b001, c, m);
        check(c == 3'b001, "R3 IR capture pattern", c, 3'b001);
        scan_dr(12, 64'h9C6, d, ok);
        check(d[11:0] == 12'h5A3, "R7 capture order", d[11:0], 12'h5A3);
        check(pad_out == 4'hA && pad_oe == 4'h5 && !test_sel, "R7 pins stay core",
              {test_sel, pad_oe, pad_out}, 9'h05A);
        scan_ir(3'b000, c, m);
        check(m == 1'b0, "R3 no effect before update", m, 0);
        check(test_sel == 1'b1, "R8 test_sel", test_sel, 1);
        check(pad_out == 4'hC && pad_oe == 4'h9, "R8 pins from preload",
              {pad_oe, pad_out}, 8'h9C);
        scan_dr(12, 64'h3F0, d, ok);
        check(d[11:0] == 12'h5A3, "R7 capture under external test", d[11:0], 12'h5A3);
        check(pad_out == 4'hF && pad_oe == 4'h3, "R12 update under external test",
              {pad_oe, pad_out}, 8'h3F);
    endtask

    task automatic t_clamp;
        logic [63:0] d;
        bit ok;
        load_ir(3'b100);
        check(test_sel && pad_out == 4'hF && pad_oe == 4'h3, "R9 clamp drives held",
              {test_sel, pad_oe, pad_out}, 9'h13F);
        scan_dr(8, 64'hB5, d, ok);
        check(d[7:0] == 8'h6A, "R9 clamp one-bit path", d[7:0], 8'h6A);
        core_out = 4'h0; core_oe = 4'hF;
        #4;
        check(pad_out == 4'hF && pad_oe == 4'h3, "R9 R12 clamp holds pins",
              {pad_oe, pad_out}, 8'h3F);
    endtask

    task automatic t_highz;
        logic [63:0] d;
        bit ok;
        load_ir(3'b011);
        check(pad_oe == 4'h0 && test_sel, "R10 all enables off", {test_sel, pad_oe}, 5'h10);
        scan_dr(8, 64'hB5, d, ok);
        check(d[7:0] == 8'h6A, "R10 one-bit path", d[7:0], 8'h6A);
    endtask

    task automatic t_tdo_edge;
        logic o, oe;
        load_ir(3'b111);
        step(1); step(0); step(0);      // now in DR-Shift, flop holds 0
        tick(0, 1'b1, o, oe);           // flop takes 1 on this edge
        #1;
        check(tdo == 1'b0, "R11 tdo steady after rising edge", tdo, 0);
        @(negedge tck); #1;
        check(tdo == 1'b1, "R11 tdo moves on falling edge", tdo, 1);
        step(1); step(1); step(0);
    endtask

    task automatic t_tms_reset;
        logic [63:0] d;
        bit ok;
        load_ir(3'b000);
        step(1); step(0); step(0);      // DR-Shift
        for (int i = 0; i < 5; i++) step(1);
        step(0);
        #1;
        check(test_sel == 1'b0, "R1 five ones from DR-Shift", test_sel, 0);
        scan_dr(32, 64'h0, d, ok);
        check(d[31:0] == IDEXP, "R1 identify after reset", d[31:0], IDEXP);
        load_ir(3'b100);
        step(1); step(1); step(0); step(0); step(1); step(0);   // IR-Pause
        for (int i = 0; i < 5; i++) step(1);
        step(0);
        #1;
        check(test_sel == 1'b0, "R1 five ones from IR-Pause", test_sel, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_bypass(3'b111, "R5 one-bit path");
        t_bypass(3'b101, "R6 code 101");
        t_bypass(3'b110, "R6 code 110");
        t_sample_extest;
        t_clamp;
        t_highz;
        t_tdo_edge;
        t_tms_reset;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule